// File: doc/BRIEF.md
# Pulse-Interval Symbol Decoder

This block turns a sampled pulse-interval downlink line into data bits. Each symbol opens with a rising edge and a high level. The number of sample cycles the line stays high decides the value. A short high level followed by a low level at the check point gives a 0. A long high level gives a 1. Any other timing is flagged as a symbol error. Symbols have no fixed length: the cell timer starts again on every new rising edge, and once a 0 is settled the block goes idle early and waits for the next rise.

The line is sampled every clock cycle; at the nominal 10 MHz sample rate one cycle is 100 ns. Every time point is a parameter counted in cycles from the sample that shows the rising edge. A 0 needs a fall between 2.9 and 4.2 µs and a low level at 5.2 µs. A 1 needs a fall between 6.1 and 10.5 µs. Falls in the gap between those windows, falls that come too early, and a high level still present at 10.5 µs are all errors. After a decision or an error, the block waits for a fresh rising edge. While the enable is low, the block produces nothing and abandons any symbol in progress.

Top module: `pie_sym_dec`

## Requirements
- R1: During and after reset, with no rising edge on `data_i`, `bit_valid_o`, `bit_o` and `sym_err_o` are all 0.
- R2: A high level of 29 to 42 cycles (inclusive) with the line still low at cycle 52 after the rise gives a 0. The block strobes `bit_valid_o` with `bit_o` = 0 two clocks after cycle 52.
- R3: A high level of 61 to 105 cycles (inclusive) gives a 1. The block strobes `bit_valid_o` with `bit_o` = 1 two clocks after the first low sample.
- R4: A high level shorter than 29 cycles strobes `sym_err_o` two clocks after the first low sample.
- R5: A high level of 43 to 60 cycles, which lies in the forbidden gap, strobes `sym_err_o` two clocks after the first low sample.
- R6: If the line is still high at cycle 105, `sym_err_o` strobes at once, without waiting for a fall. It appears two clocks after that sample.
- R7: In a 0 symbol, a new rising edge at or before cycle 52 strobes `sym_err_o` two clocks after the rise, and no bit is produced.
- R8: `bit_valid_o` and `sym_err_o` are each one cycle wide, are never high together, and there is exactly one of them per symbol.
- R9: After a decision or an error, nothing further is reported until a new rising edge starts a symbol. A fall or a long level in between has no effect.
- R10: While `en_i` is 0, both strobes are 0 from the next cycle on. A symbol in progress when `en_i` drops is discarded, and its later fall reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Decoder enable |
| data_i | input | 1 | Demodulated line level |
| bit_valid_o | output | 1 | One-cycle strobe when a bit is decided |
| bit_o | output | 1 | Decided bit value, meaningful with the strobe |
| sym_err_o | output | 1 | One-cycle strobe on a malformed symbol |

## Verification
The line goes through one input register, and every result is registered once more. A result therefore appears two clocks after the sample that decides it. With the rise sample taken as cycle 0, a 1, a short fall or a gap fall is due at cycle H+2 for a high level of H cycles. A 0 is due at cycle 54, a timeout at cycle 107, and an early rise at R+2. The bench drives on falling edges and counts rising edges. A monitor reads the outputs 2 ns after each rising edge and records the count and the cycle of every strobe. At the end of each symbol, the bench compares that record with the cycle and kind that its own expectation function computes from the high length, so a result that is late, early, repeated or missing is caught.

// File: rtl/pie_dec_pkg.sv
`timescale 1ns/1ps
package pie_dec_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HIGH,
    ST_LOW0
  } pie_state_e;

  typedef enum logic [1:0] {
    CLS_SHORT,
    CLS_ZERO,
    CLS_GAP,
    CLS_ONE
  } pie_cls_e;
endpackage

// File: rtl/pie_edge_det.sv
`timescale 1ns/1ps
module pie_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic cur_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= data_i;
      prev_q <= cur_q;
    end
  end

  assign lvl_o  = cur_q;
  assign rise_o = cur_q & ~prev_q;
  assign fall_o = ~cur_q & prev_q;
endmodule

// File: rtl/pie_cell_timer.sv
`timescale 1ns/1ps
module pie_cell_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (restart_i)     cnt_q <= CNT_W'(1);
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pie_fall_class.sv
`timescale 1ns/1ps
module pie_fall_class
  import pie_dec_pkg::*;
#(
  parameter int CNT_W = 7,
  parameter int Z_MIN = 29,
  parameter int Z_MAX = 42,
  parameter int O_MIN = 61,
  parameter int O_MAX = 105
) (
  input  logic [CNT_W-1:0] cnt_i,
  output pie_cls_e         cls_o
);
  always_comb begin
    if (cnt_i < CNT_W'(Z_MIN))       cls_o = CLS_SHORT;
    else if (cnt_i <= CNT_W'(Z_MAX)) cls_o = CLS_ZERO;
    else if (cnt_i < CNT_W'(O_MIN))  cls_o = CLS_GAP;
    else if (cnt_i <= CNT_W'(O_MAX)) cls_o = CLS_ONE;
    else                             cls_o = CLS_GAP;
  end
endmodule

// File: rtl/pie_sym_dec.sv
`timescale 1ns/1ps
module pie_sym_dec
  import pie_dec_pkg::*;
#(
  parameter int Z_MIN  = 29,
  parameter int Z_MAX  = 42,
  parameter int O_MIN  = 61,
  parameter int O_MAX  = 105,
  parameter int LO_CHK = 52
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic data_i,
  output logic bit_valid_o,
  output logic bit_o,
  output logic sym_err_o
);
  localparam int CNT_W = $clog2(O_MAX + 2);

  logic             lvl, rise, fall;
  logic [CNT_W-1:0] cnt;
  pie_cls_e         cls;
  pie_state_e       state_q, state_d;
  logic             restart, run;
  logic             v_d, b_d, e_d;
  logic             v_q, b_q, e_q;

  pie_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  pie_cell_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (run),
    .cnt_o     (cnt)
  );

  pie_fall_class #(
    .CNT_W (CNT_W),
    .Z_MIN (Z_MIN),
    .Z_MAX (Z_MAX),
    .O_MIN (O_MIN),
    .O_MAX (O_MAX)
  ) u_class (
    .cnt_i (cnt),
    .cls_o (cls)
  );

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    run     = (state_q != ST_IDLE);
    v_d     = 1'b0;
    b_d     = 1'b0;
    e_d     = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
      run     = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rise) begin
            state_d = ST_HIGH;
            restart = 1'b1;
          end
        end
        ST_HIGH: begin
          if (fall) begin
            unique case (cls)
              CLS_ZERO: state_d = ST_LOW0;
              CLS_ONE: begin
                v_d     = 1'b1;
                b_d     = 1'b1;
                state_d = ST_IDLE;
              end
              default: begin
                e_d     = 1'b1;
                state_d = ST_IDLE;
              end
            endcase
          end else if (cnt == CNT_W'(O_MAX)) begin
            // still high at the last legal fall point
            e_d     = 1'b1;
            state_d = ST_IDLE;
          end
        end
        ST_LOW0: begin
          if (rise) begin
            e_d     = 1'b1;
            state_d = ST_IDLE;
          end else if (cnt == CNT_W'(LO_CHK)) begin
            v_d     = ~lvl;
            e_d     = lvl;
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      v_q     <= 1'b0;
      b_q     <= 1'b0;
      e_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      v_q     <= v_d;
      b_q     <= b_d;
      e_q     <= e_d;
    end
  end

  assign bit_valid_o = v_q;
  assign bit_o       = b_q;
  assign sym_err_o   = e_q;
endmodule

// File: rtl/pie_sym_dec_chk.sv
`timescale 1ns/1ps
module pie_sym_dec_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic data_i,
  input logic bit_valid_o,
  input logic bit_o,
  input logic sym_err_o
);
  // R8
  excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_valid_o && sym_err_o));

  // R8
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  // R8
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_err_o |=> !sym_err_o);

  // R10
  en_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!bit_valid_o && !sym_err_o));

  // R3
  one_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && bit_o) |-> (!$past(data_i, 2) && $past(data_i, 3)));

  // R2
  zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !bit_o) |-> !$past(data_i, 2));
endmodule

bind pie_sym_dec pie_sym_dec_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .data_i      (data_i),
  .bit_valid_o (bit_valid_o),
  .bit_o       (bit_o),
  .sym_err_o   (sym_err_o)
);

// File: tb/pie_sym_dec_tb_top.sv
`timescale 1ns/1ps
module pie_sym_dec_tb_top;
  localparam int K_NONE = 0, K_ZERO = 1, K_ONE = 2, K_ERR = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic data = 1'b0;
  logic bit_valid, bit_val, sym_err;
  int   cyc = 0;
  int   checks = 0, errs = 0;
  int   ev_n = 0, ev_kind = 0, ev_cyc = 0;
  bit   both_seen = 1'b0;
  int   t0 = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pie_sym_dec dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .data_i      (data),
    .bit_valid_o (bit_valid),
    .bit_o       (bit_val),
    .sym_err_o   (sym_err)
  );

  always @(posedge clk) begin
    #2;
    if (bit_valid && sym_err) both_seen = 1'b1;
    if (bit_valid || sym_err) begin
      ev_n = ev_n + 1;
      if (ev_n == 1) begin
        ev_kind = sym_err ? K_ERR : (bit_val ? K_ONE : K_ZERO);
        ev_cyc  = cyc;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic void expect_for(input int h, input int total,
                                     output int kind, output int dcyc);
    if (h < 29) begin kind = K_ERR; dcyc = h + 2; end
    else if (h <= 42) begin
      if (total <= 52) begin kind = K_ERR; dcyc = total + 2; end
      else begin kind = K_ZERO; dcyc = 54; end
    end
    else if (h <= 60) begin kind = K_ERR; dcyc = h + 2; end
    else if (h <= 105) begin kind = K_ONE; dcyc = h + 2; end
    else begin kind = K_ERR; dcyc = 107; end
  endfunction

  task automatic clear_ev();
    ev_n = 0; ev_kind = K_NONE; ev_cyc = 0; both_seen = 1'b0;
  endtask

  task automatic send(input int h, input int total);
    @(negedge clk);
    clear_ev();
    t0 = cyc;
    data = 1'b1;
    repeat (h) @(negedge clk);
    data = 1'b0;
    repeat (total - h) @(negedge clk);
  endtask

  task automatic check_sym(input string req, input int h, input int total);
    int kind, dcyc;
    expect_for(h, total, kind, dcyc);
    chk(ev_n == 1, {req, " event count"}, ev_n, 1);
    chk(ev_kind == kind, {req, " kind"}, ev_kind, kind);
    chk(ev_cyc - t0 == dcyc, {req, " cycle"}, ev_cyc - t0, dcyc);
    chk(!both_seen, "R8 both strobes", 1, 0);
  endtask

  task automatic run_sym(input string req, input int h, input int total);
    send(h, total);
    check_sym(req, h, total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!bit_valid && !bit_val && !sym_err, "R1 during reset", {bit_valid, bit_val, sym_err}, 0);
    rst_n = 1'b1;
    clear_ev();
    repeat (20) @(negedge clk);
    chk(ev_n == 0, "R1 idle after reset", ev_n, 0);

    // boundaries
    run_sym("R4 h=28", 28, 70);
    run_sym("R2 h=29", 29, 60);
    run_sym("R2 h=42", 42, 60);
    run_sym("R5 h=43", 43, 60);
    run_sym("R5 h=60", 60, 75);
    run_sym("R3 h=61", 61, 70);
    run_sym("R3 h=105", 105, 115);
    run_sym("R6 h=106", 106, 125);
    run_sym("R6_R9 h=150", 150, 170);
    run_sym("R4 h=1", 1, 40);

    // R7: rise at cycle 45 inside a zero symbol, then R9 quiet
    @(negedge clk);
    clear_ev();
    t0 = cyc;
    data = 1'b1;
    repeat (35) @(negedge clk);
    data = 1'b0;
    repeat (10) @(negedge clk);
    data = 1'b1;
    repeat (30) @(negedge clk);
    data = 1'b0;
    repeat (40) @(negedge clk);
    chk(ev_n == 1, "R7_R9 event count", ev_n, 1);
    chk(ev_kind == K_ERR, "R7 kind", ev_kind, K_ERR);
    chk(ev_cyc - t0 == 47, "R7 cycle", ev_cyc - t0, 47);

    // R10: disabled for a whole symbol
    en = 1'b0;
    send(35, 60);
    chk(ev_n == 0, "R10 disabled symbol", ev_n, 0);
    send(80, 95);
    chk(ev_n == 0, "R10 disabled one-symbol", ev_n, 0);
    en = 1'b1;
    repeat (5) @(negedge clk);

    // R10: enable dropped mid-symbol
    @(negedge clk);
    clear_ev();
    data = 1'b1;
    repeat (40) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (38) @(negedge clk);
    data = 1'b0;
    repeat (40) @(negedge clk);
    chk(ev_n == 0, "R10 abandoned symbol", ev_n, 0);

    // block still works afterwards
    run_sym("R3 after enable", 70, 85);

    // random symbols
    for (int i = 0; i < 300; i++) begin
      int h, total;
      string req;
      h = $urandom_range(130, 1);
      if (h >= 29 && h <= 42) total = 56 + $urandom_range(15, 0);
      else total = h + $urandom_range(20, 3);
      if (h < 29) req = "R4 rand";
      else if (h <= 42) req = "R2 rand";
      else if (h <= 60) req = "R5 rand";
      else if (h <= 105) req = "R3 rand";
      else req = "R6 rand";
      run_sym(req, h, total);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule